// File: doc/BRIEF.md
# Video Line to Parallel Port Bridge

The bridge accepts two 8-bit pixel streams that share one pixel clock, together with an active-line qualifier and a frame pulse. It writes each sampled pixel pair into an asynchronous FIFO, along with flags that mark the first word of a line and the first line of a frame. On a separate, free-running port clock it replays those words to a synchronous parallel receiver. The receiver sees channel A, channel B, a one-cycle start strobe on the first word of each line, a frame marker, and an enable that qualifies every valid word.

A receiver downstream counts a fixed number of words per line and uses the start strobe to realign. The bridge therefore delivers only complete lines of exactly `LINE_WORDS` words. Surplus pixels in a long line are dropped. A short line, or a line that meets a full FIFO, is withdrawn from the FIFO before the read side can see any of it. A line is released only when the committed fill level exceeds `PE_THRESH`. From then on, enable stays high for the whole line. There is no receiver back-pressure: the port clock never stops and only the FIFO state paces the output.

Top module: `vline_port_bridge`

## Requirements
- R1: For each delivered word, `port_a` carries the stream A pixel and `port_b` carries the stream B pixel of the same sample. Words appear in capture order.
- R2: `port_start` is high for one port cycle only, on the first enabled word of a line, and never while `port_en` is low.
- R3: Every delivered line consists of exactly `LINE_WORDS` enabled words on consecutive port cycles. No enabled word appears outside a line.
- R4: A line begins only when the committed FIFO fill level is greater than `PE_THRESH`. While the fill level is at or below the threshold, `port_en` stays low. With `PE_THRESH = 2*LINE_WORDS-1`, a lone buffered line is held until a second line is committed.
- R5: Pixels after the first `LINE_WORDS` of an active line are discarded, so a long line is delivered truncated to its first `LINE_WORDS` pixels.
- R6: A line whose active period holds fewer than `LINE_WORDS` pixels is discarded entirely. The next complete line is delivered in its place.
- R7: After a pulse on `pix_frame`, the next delivered line raises `port_sof` in the same cycle as its `port_start`. `port_sof` is low on every other word and on every other line.
- R8: A pixel presented while the FIFO is full sets `pix_ovf`, and that whole line is discarded. Lines that are delivered remain complete and in order. `pix_ovf` stays set until `pix_rst_n` is asserted.
- R9: While reset is asserted and right after it, `port_en`, `port_start`, `port_sof` and `pix_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel capture clock |
| pix_rst_n | input | 1 | Active-low reset, pixel domain |
| pix_line | input | 1 | High while the active pixels of a line are present |
| pix_frame | input | 1 | One-cycle pulse announcing a new frame |
| pix_a | input | 8 | Stream A pixel |
| pix_b | input | 8 | Stream B pixel |
| pix_ovf | output | 1 | Sticky overflow flag, pixel domain |
| port_clk | input | 1 | Free-running port clock |
| port_rst_n | input | 1 | Active-low reset, port domain |
| port_a | output | 8 | Channel A word |
| port_b | output | 8 | Channel B word |
| port_start | output | 1 | First word of a line |
| port_sof | output | 1 | First line of a frame, coincident with start |
| port_en | output | 1 | Word valid |

## Verification
The bench builds the bridge with `ADDR_W=5` (32 entries), `LINE_WORDS=8` and `PE_THRESH=15`. This threshold requires two whole lines before any output, so the hold-back of a single buffered line can be observed at the ports. The 32-entry FIFO, filled by a 125 MHz pixel clock and drained at 50 MHz, overflows within a few back-to-back lines, which brings the discard path and the sticky flag into reach. Short eight-pixel lines also let long, short and frame-marked lines be mixed in one short run.

// File: rtl/vlb_pkg.sv
package vlb_pkg;

   localparam int CHAN_W = 8;

   // One FIFO word: the two pixels plus the sync state that travels with them
   typedef struct packed {
      logic              sol;   // first word of a line
      logic              sof;   // first word of a frame's first line
      logic [CHAN_W-1:0] a;
      logic [CHAN_W-1:0] b;
   } vlb_entry_t;

endpackage

// File: rtl/vlb_sync.sv
module vlb_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("vlb_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/vlb_mem.sv
module vlb_mem #(
   parameter int ADDR_W = 6,
   parameter int WIDTH  = 18
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/vlb_wr_side.sv
module vlb_wr_side
   import vlb_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LINE_WORDS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_act,
   input  logic              frame_sync,
   input  logic [CHAN_W-1:0] a_in,
   input  logic [CHAN_W-1:0] b_in,
   input  logic [ADDR_W:0]   rd_gray_s,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output vlb_entry_t        wr_data,
   output logic [ADDR_W:0]   commit_gray,
   output logic              ovf
);

   localparam int             PW        = ADDR_W + 1;
   localparam logic [ADDR_W:0] DEPTH_P  = PW'(1 << ADDR_W);
   localparam int             CNT_W     = $clog2(LINE_WORDS + 1);
   localparam logic [CNT_W-1:0] FULL_LN = CNT_W'(LINE_WORDS);

   function automatic logic [ADDR_W:0] gray_to_bin(input logic [ADDR_W:0] g);
      logic [ADDR_W:0] r;
      r[ADDR_W] = g[ADDR_W];
      for (int i = ADDR_W - 1; i >= 0; i--) r[i] = r[i+1] ^ g[i];
      return r;
   endfunction

   logic              act_q;
   logic [ADDR_W:0]   wptr;      // speculative: includes the line being captured
   logic [ADDR_W:0]   cptr;      // committed: whole lines only
   logic [CNT_W-1:0]  cnt;
   logic              bad;
   logic              line_sof;
   logic              frame_pend;

   logic              first_px, line_end;
   logic [CNT_W-1:0]  cnt_eff;
   logic              bad_eff;
   logic [ADDR_W:0]   rd_bin;
   logic              full, take, drop_ev, commit_ok;

   always_comb begin
      first_px  = line_act & ~act_q;
      line_end  = ~line_act & act_q;
      cnt_eff   = first_px ? '0 : cnt;
      bad_eff   = first_px ? 1'b0 : bad;
      rd_bin    = gray_to_bin(rd_gray_s);
      full      = ((wptr - rd_bin) == DEPTH_P);
      take      = line_act & ~bad_eff & (cnt_eff < FULL_LN);
      drop_ev   = take & full;
      commit_ok = line_end & ~bad & (cnt == FULL_LN);
   end

   assign wr_en   = take & ~full;
   assign wr_addr = wptr[ADDR_W-1:0];
   assign wr_data = '{sol: (cnt_eff == '0),
                      sof: (cnt_eff == '0) & frame_pend,
                      a:   a_in,
                      b:   b_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q       <= 1'b0;
         wptr        <= '0;
         cptr        <= '0;
         cnt         <= '0;
         bad         <= 1'b0;
         line_sof    <= 1'b0;
         frame_pend  <= 1'b0;
         ovf         <= 1'b0;
         commit_gray <= '0;
      end else begin
         act_q <= line_act;
         bad   <= bad_eff | drop_ev;
         cnt   <= cnt_eff + CNT_W'(wr_en);
         if (first_px) line_sof <= frame_pend;
         if (line_end) begin
            if (commit_ok) cptr <= wptr;
            else           wptr <= cptr;   // withdraw a short or overflowed line
         end else if (wr_en) begin
            wptr <= wptr + 1'b1;
         end
         if (frame_sync)                 frame_pend <= 1'b1;
         else if (commit_ok && line_sof) frame_pend <= 1'b0;
         if (drop_ev) ovf <= 1'b1;
         commit_gray <= cptr ^ (cptr >> 1);
      end
   end

endmodule

// File: rtl/vlb_rd_side.sv
module vlb_rd_side
   import vlb_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LINE_WORDS = 16,
   parameter int PE_THRESH  = 15,
   parameter bit BLANK_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W:0]   wr_gray_s,
   input  vlb_entry_t        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W:0]   rd_gray,
   output logic [CHAN_W-1:0] out_a,
   output logic [CHAN_W-1:0] out_b,
   output logic              out_start,
   output logic              out_sof,
   output logic              out_en
);

   localparam int              PW       = ADDR_W + 1;
   localparam logic [ADDR_W:0] THR      = PW'(PE_THRESH);
   localparam int              POS_W    = $clog2(LINE_WORDS);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_WORDS - 1);

   function automatic logic [ADDR_W:0] gray_to_bin(input logic [ADDR_W:0] g);
      logic [ADDR_W:0] r;
      r[ADDR_W] = g[ADDR_W];
      for (int i = ADDR_W - 1; i >= 0; i--) r[i] = r[i+1] ^ g[i];
      return r;
   endfunction

   logic [ADDR_W:0]  rptr;
   logic [POS_W-1:0] pos;
   logic             busy;
   logic [ADDR_W:0]  fill;
   logic             rd, last_word;

   always_comb begin
      fill      = gray_to_bin(wr_gray_s) - rptr;
      // threshold is consulted only between lines
      rd        = busy | (fill > THR);
      last_word = (pos == LAST_POS);
   end

   assign rd_addr = rptr[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr      <= '0;
         pos       <= '0;
         busy      <= 1'b0;
         rd_gray   <= '0;
         out_en    <= 1'b0;
         out_start <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         if (rd) begin
            rptr <= rptr + 1'b1;
            pos  <= last_word ? '0 : pos + 1'b1;
            busy <= ~last_word;
         end
         rd_gray   <= rptr ^ (rptr >> 1);
         out_en    <= rd;
         out_start <= rd & rd_data.sol;
         out_sof   <= rd & rd_data.sol & rd_data.sof;
      end
   end

   if (BLANK_IDLE) begin : g_blank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_a <= '0;
            out_b <= '0;
         end else begin
            out_a <= rd ? rd_data.a : '0;
            out_b <= rd ? rd_data.b : '0;
         end
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_a <= '0;
            out_b <= '0;
         end else if (rd) begin
            out_a <= rd_data.a;
            out_b <= rd_data.b;
         end
      end
   end

endmodule

// File: rtl/vline_port_bridge.sv
module vline_port_bridge
   import vlb_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int LINE_WORDS  = 16,
   parameter int PE_THRESH   = 15,
   parameter int SYNC_STAGES = 2,
   parameter bit BLANK_IDLE  = 1'b1
) (
   input  logic              pix_clk,
   input  logic              pix_rst_n,
   input  logic              pix_line,
   input  logic              pix_frame,
   input  logic [CHAN_W-1:0] pix_a,
   input  logic [CHAN_W-1:0] pix_b,
   output logic              pix_ovf,
   input  logic              port_clk,
   input  logic              port_rst_n,
   output logic [CHAN_W-1:0] port_a,
   output logic [CHAN_W-1:0] port_b,
   output logic              port_start,
   output logic              port_sof,
   output logic              port_en
);

   localparam int DEPTH   = 1 << ADDR_W;
   localparam int ENTRY_W = $bits(vlb_entry_t);

   if (LINE_WORDS < 2) begin : g_chk_len
      $error("vline_port_bridge: LINE_WORDS must be at least 2");
   end
   if (PE_THRESH < LINE_WORDS - 1) begin : g_chk_thr_lo
      $error("vline_port_bridge: PE_THRESH must cover one whole line");
   end
   if (DEPTH < PE_THRESH + LINE_WORDS) begin : g_chk_depth
      $error("vline_port_bridge: FIFO too small for threshold plus one line");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("vline_port_bridge: SYNC_STAGES must be at least 2");
   end

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   vlb_entry_t        wr_data, rd_data;
   logic [ADDR_W:0]   commit_gray, commit_gray_s;
   logic [ADDR_W:0]   rd_gray, rd_gray_s;

   vlb_wr_side #(
      .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)
   ) u_wr (
      .clk(pix_clk), .rst_n(pix_rst_n),
      .line_act(pix_line), .frame_sync(pix_frame),
      .a_in(pix_a), .b_in(pix_b),
      .rd_gray_s(rd_gray_s),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit_gray(commit_gray), .ovf(pix_ovf)
   );

   vlb_mem #(
      .ADDR_W(ADDR_W), .WIDTH(ENTRY_W)
   ) u_mem (
      .wclk(pix_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
      .raddr(rd_addr), .rdata(rd_data)
   );

   vlb_sync #(
      .WIDTH(ADDR_W + 1), .STAGES(SYNC_STAGES)
   ) u_sync_w2r (
      .clk(port_clk), .rst_n(port_rst_n), .d(commit_gray), .q(commit_gray_s)
   );

   vlb_sync #(
      .WIDTH(ADDR_W + 1), .STAGES(SYNC_STAGES)
   ) u_sync_r2w (
      .clk(pix_clk), .rst_n(pix_rst_n), .d(rd_gray), .q(rd_gray_s)
   );

   vlb_rd_side #(
      .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS),
      .PE_THRESH(PE_THRESH), .BLANK_IDLE(BLANK_IDLE)
   ) u_rd (
      .clk(port_clk), .rst_n(port_rst_n),
      .wr_gray_s(commit_gray_s), .rd_data(rd_data),
      .rd_addr(rd_addr), .rd_gray(rd_gray),
      .out_a(port_a), .out_b(port_b),
      .out_start(port_start), .out_sof(port_sof), .out_en(port_en)
   );

endmodule

// File: rtl/vlb_checker.sv
module vlb_checker #(
   parameter int LINE_WORDS = 16
) (
   input logic port_clk,
   input logic port_rst_n,
   input logic port_en,
   input logic port_start,
   input logic port_sof,
   input logic pix_clk,
   input logic pix_rst_n,
   input logic pix_ovf
);

   localparam int             CW  = $clog2(LINE_WORDS + 1) + 1;
   localparam logic [CW-1:0]  LEN = CW'(LINE_WORDS);

   // enabled words seen since the latest start
   logic [CW-1:0] seen;

   always_ff @(posedge port_clk or negedge port_rst_n) begin
      if (!port_rst_n)    seen <= '0;
      else if (port_en)   seen <= port_start ? CW'(1) : seen + 1'b1;
   end

   p_start_has_en_r2: assert property (@(posedge port_clk) disable iff (!port_rst_n)
      port_start |-> port_en);

   p_start_one_cycle_r2: assert property (@(posedge port_clk) disable iff (!port_rst_n)
      port_start |=> !port_start);

   p_start_after_whole_line_r3: assert property (@(posedge port_clk) disable iff (!port_rst_n)
      port_start |-> (seen == '0 || seen == LEN));

   p_no_gap_in_line_r3: assert property (@(posedge port_clk) disable iff (!port_rst_n)
      (seen != '0 && seen != LEN) |-> port_en);

   p_no_word_outside_line_r3: assert property (@(posedge port_clk) disable iff (!port_rst_n)
      (port_en && !port_start) |-> (seen != '0 && seen != LEN));

   p_sof_with_start_r7: assert property (@(posedge port_clk) disable iff (!port_rst_n)
      port_sof |-> port_start);

   p_ovf_sticky_r8: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
      pix_ovf |=> pix_ovf);

endmodule

bind vline_port_bridge vlb_checker #(.LINE_WORDS(LINE_WORDS)) u_chk (
   .port_clk(port_clk), .port_rst_n(port_rst_n),
   .port_en(port_en), .port_start(port_start), .port_sof(port_sof),
   .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_ovf(pix_ovf)
);

// File: tb/vline_port_bridge_tb_top.sv
module vline_port_bridge_tb_top;

   localparam int L   = 8;
   localparam int AW  = 5;
   localparam int THR = 15;

   logic       pix_clk = 1'b0, port_clk = 1'b0;
   logic       pix_rst_n = 1'b0, port_rst_n = 1'b0;
   logic       pix_line = 1'b0, pix_frame = 1'b0;
   logic [7:0] pix_a = '0, pix_b = '0;
   logic       pix_ovf;
   logic [7:0] port_a, port_b;
   logic       port_start, port_sof, port_en;

   always #4  pix_clk  = ~pix_clk;    // 125 MHz pixel clock
   always #10 port_clk = ~port_clk;   // 50 MHz port clock

   vline_port_bridge #(
      .ADDR_W(AW), .LINE_WORDS(L), .PE_THRESH(THR), .SYNC_STAGES(2), .BLANK_IDLE(1'b1)
   ) dut_i (
      .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_line(pix_line),
      .pix_frame(pix_frame), .pix_a(pix_a), .pix_b(pix_b), .pix_ovf(pix_ovf),
      .port_clk(port_clk), .port_rst_n(port_rst_n),
      .port_a(port_a), .port_b(port_b), .port_start(port_start),
      .port_sof(port_sof), .port_en(port_en)
   );

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- port-side monitor ----------------
   int         em_n = 0;
   logic [7:0] em_id  [64];
   bit         em_sof [64];
   bit         em_ok  [64];
   int         words_seen = 0;
   int         mon_cnt = 0;
   logic [7:0] mon_id = '0;
   bit         mon_ok = 1'b0, mon_sof = 1'b0;

   always @(negedge port_clk) begin
      if (port_rst_n) begin
         if (port_start && !port_en) chk(1'b0, "R2 start without enable", 1, 0);
         if (port_en) begin
            words_seen++;
            if (port_start) begin
               if (mon_cnt != 0) chk(1'b0, "R3 start inside line, words so far", mon_cnt, L);
               mon_cnt = 1;
               mon_id  = port_a;
               mon_sof = port_sof;
               mon_ok  = (port_b == {port_a[3:0], 4'h0});
            end else if (mon_cnt == 0) begin
               chk(1'b0, "R2 enabled word without start", 0, 1);
            end else begin
               mon_ok = mon_ok && (port_a == mon_id) &&
                        (port_b == {mon_id[3:0], mon_cnt[3:0]});
               if (port_sof) chk(1'b0, "R7 sof away from start", 1, 0);
               mon_cnt++;
            end
            if (mon_cnt == L) begin
               chk(1'b1, "R3 line complete", L, L);
               if (em_n < 64) begin
                  em_id[em_n]  = mon_id;
                  em_sof[em_n] = mon_sof;
                  em_ok[em_n]  = mon_ok;
                  em_n++;
               end
               mon_cnt = 0;
            end
         end else if (mon_cnt != 0) begin
            chk(1'b0, "R3 enable gap inside line, words so far", mon_cnt, L);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send_line(input int id, input int npix, input int gap);
      for (int k = 0; k < npix; k++) begin
         @(negedge pix_clk);
         pix_line = 1'b1;
         pix_a    = 8'(id);
         pix_b    = {4'(id), 4'(k)};
      end
      @(negedge pix_clk);
      pix_line = 1'b0;
      pix_a    = '0;
      pix_b    = '0;
      for (int g = 1; g < gap; g++) @(negedge pix_clk);
   endtask

   task automatic port_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge port_clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      port_wait(2);
      chk(port_en == 1'b0,    "R9 port_en low after reset",    int'(port_en), 0);
      chk(port_start == 1'b0, "R9 port_start low after reset", int'(port_start), 0);
      chk(port_sof == 1'b0,   "R9 port_sof low after reset",   int'(port_sof), 0);
      chk(pix_ovf == 1'b0,    "R9 pix_ovf low after reset",    int'(pix_ovf), 0);
   endtask

   task automatic t_threshold;
      send_line(1, L, 4);
      port_wait(40);
      chk(words_seen == 0, "R4 single line held below threshold", words_seen, 0);
      send_line(2, L, 4);
      port_wait(40);
      chk(em_n == 1, "R4 one line released after second commit", em_n, 1);
      chk(em_id[0] == 8'd1, "R4 released line id", int'(em_id[0]), 1);
   endtask

   task automatic t_stream;
      for (int id = 3; id <= 6; id++) send_line(id, L, 4);
      port_wait(80);
      chk(em_n == 5, "R1 lines delivered in stream test", em_n, 5);
      for (int i = 0; i < 5; i++) begin
         chk(em_id[i] == 8'(i + 1), "R1 line order", int'(em_id[i]), i + 1);
         chk(em_ok[i], "R1 channel A/B content", int'(em_ok[i]), 1);
      end
   endtask

   task automatic t_long_short;
      send_line(7, L + 4, 4);   // long line, truncated
      send_line(8, L - 3, 4);   // short line, discarded
      send_line(9, L, 4);
      port_wait(60);
      chk(em_n == 7, "R5 lines delivered after long line", em_n, 7);
      chk(em_id[6] == 8'd7, "R5 truncated line id", int'(em_id[6]), 7);
      chk(em_ok[6], "R5 truncated line holds first pixels only", int'(em_ok[6]), 1);
   endtask

   task automatic t_frame;
      @(negedge pix_clk);
      pix_frame = 1'b1;
      @(negedge pix_clk);
      pix_frame = 1'b0;
      send_line(10, L, 4);
      port_wait(60);
      chk(em_n == 8, "R6 count after short line", em_n, 8);
      chk(em_id[7] == 8'd9, "R6 short line skipped, next id", int'(em_id[7]), 9);
      chk(em_sof[7] == 1'b0, "R7 line before frame pulse has no sof", int'(em_sof[7]), 0);
      send_line(11, L, 4);
      port_wait(60);
      chk(em_n == 9, "R7 count after frame line", em_n, 9);
      chk(em_id[8] == 8'd10, "R7 frame line id", int'(em_id[8]), 10);
      chk(em_sof[8] == 1'b1, "R7 frame line carries sof", int'(em_sof[8]), 1);
      chk(pix_ovf == 1'b0, "R8 no overflow in paced traffic", int'(pix_ovf), 0);
   endtask

   task automatic t_overflow;
      int base;
      int prev;
      bit ordered;
      bit intact;
      base = em_n;
      for (int id = 20; id < 44; id++) send_line(id, L, 1);
      port_wait(400);
      chk(pix_ovf == 1'b1, "R8 overflow flag set", int'(pix_ovf), 1);
      chk((em_n - base) <= 20, "R8 lines dropped under overflow, delivered", em_n - base, 20);
      ordered = 1'b1;
      intact  = 1'b1;
      prev    = int'(em_id[base - 1]);
      for (int i = base; i < em_n; i++) begin
         if (int'(em_id[i]) <= prev) ordered = 1'b0;
         if (!em_ok[i]) intact = 1'b0;
         prev = int'(em_id[i]);
      end
      chk(ordered, "R8 surviving lines in order", int'(ordered), 1);
      chk(intact, "R8 surviving lines intact", int'(intact), 1);
      port_wait(50);
      chk(pix_ovf == 1'b1, "R8 overflow flag sticky", int'(pix_ovf), 1);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      port_wait(10);
      pix_rst_n  = 1'b1;
      port_rst_n = 1'b1;
      t_reset();
      t_threshold();
      t_stream();
      t_long_short();
      t_frame();
      t_overflow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule